// File: doc/BRIEF.md
# Clocked Inertial Delay Filter

This block filters a single-bit signal through a delay of `DELAY` clock cycles. In its default inertial mode, a new level reaches the output only if the input has held that level for the whole delay window. A pulse that is shorter than the window is dropped without a trace. The block tracks at most one pending transition, using a target level and a down-counter. When the input falls back to the current output level before the counter runs out, the pending transition is cancelled, and the next departure starts a fresh, full window.

A static mode parameter selects a transport variant instead. In that variant, a `DELAY`-deep shift line passes every pulse unchanged, whatever its width. A delay of zero turns the block into a plain wire from input to output. Typical uses are deglitching a slow status line, or modelling the two delay disciplines side by side in a larger design.

Top module: `inertia_filter`

## Requirements
- R1: While `rst_i` (active high, synchronous) is high at a rising edge, the output is 0 after that edge, any pending transition is dropped, and every transport stage reads 0. A block with `DELAY` = 0 has no state and keeps following its input.
- R2: In inertial mode (the default), a level that differs from the output and is sampled on `DELAY` consecutive rising edges appears on `sig_o` just after the last of those edges. It never appears earlier.
- R3: In inertial mode, a level held for fewer than `DELAY` consecutive sampled edges leaves `sig_o` unchanged.
- R4: In inertial mode, the input returning to the output level cancels the pending transition. The next departure then needs a full new window, so back-to-back narrow pulses never add up to an output change.
- R5: In transport mode (`MODE` = transport), every input transition appears on `sig_o` exactly `DELAY` cycles later, including single-cycle pulses.
- R6: With `DELAY` = 1, `sig_o` is the input registered by one rising edge.
- R7: With `DELAY` = 0, `sig_o` equals `sig_i` combinationally, with no added cycle.
- R8: In inertial mode, once `sig_o` changes it keeps its value for at least the next `DELAY`-1 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Signal to be delayed and filtered |
| sig_o | output | 1 | Delayed (and, in inertial mode, filtered) signal |

## Verification
The assertions assume the following about the inputs:
- `sig_i` is synchronous to `clk_i` and is never unknown once reset has been released.
- `rst_i` is high at the first rising edge, so the commit, cancel and spacing properties start from a cleared state.

The stimulus stays within these limits:
- The bench changes `sig_i` and `rst_i` only on falling edges, and holds reset from time zero.
- Apart from a deliberate mid-run reset, it varies only the pulse widths and gaps around the window length.

// File: rtl/inertia_pkg.sv
package inertia_pkg;

  typedef enum logic {
    DLY_INERTIAL  = 1'b0,
    DLY_TRANSPORT = 1'b1
  } dly_mode_e;

  // Counter value loaded when a departure is first seen: the first sample
  // counts as one, the commit edge itself counts as one more.
  function automatic int unsigned window_load(input int unsigned d);
    return (d >= 2) ? d - 2 : 0;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned d);
    return (d > 2) ? $clog2(d - 1) : 1;
  endfunction

  // Width of the spacing counter that saturates at d-1.
  function automatic int unsigned gap_bits(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

endpackage

// File: rtl/inertia_pend.sv
module inertia_pend
  import inertia_pkg::*;
#(
  parameter int unsigned DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic sig_o
);

  localparam int unsigned CW       = cnt_bits(DELAY);
  localparam logic [CW-1:0] LOAD   = CW'(window_load(DELAY));
  localparam int unsigned GW       = gap_bits(DELAY);
  localparam logic [GW-1:0] GAP_MAX = GW'(DELAY - 1);

  logic          out_q, out_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flip_w;    // output takes the pending level this edge
  logic          cancel_w;  // pending level abandoned this edge

  always_comb begin
    out_d    = out_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    flip_w   = 1'b0;
    cancel_w = 1'b0;
    if (sig_i == out_q) begin
      cancel_w = pend_q;
      pend_d   = 1'b0;
      cnt_d    = '0;
    end else if (!pend_q) begin
      if (DELAY == 1) begin
        out_d  = sig_i;
        flip_w = 1'b1;
      end else begin
        pend_d = 1'b1;
        cnt_d  = LOAD;
      end
    end else if (cnt_q == '0) begin
      out_d  = sig_i;
      pend_d = 1'b0;
      flip_w = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      out_q  <= out_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sig_o = out_q;

  // Spacing monitor: edges since the last output change, saturating.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)            gap_q <= GAP_MAX;
    else if (flip_w)      gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (sig_o == 1'b0 && !pend_q));

  p_commit_level_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    flip_w |=> (sig_o == $past(sig_i)));

  p_cancel_holds_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    cancel_w |=> (!pend_q && sig_o == $past(sig_o)));

  p_min_spacing_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    flip_w |-> (gap_q == GAP_MAX));

endmodule

// File: rtl/transport_line.sv
module transport_line #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic sig_o
);

  logic [DELAY-1:0] stage_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= sig_i;
      for (int k = 1; k < DELAY; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sig_o = stage_q[DELAY-1];

  p_line_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (sig_o == 1'b0));

  p_quiet_line_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_q == '0 && !sig_i) |=> !sig_o);

endmodule

// File: rtl/inertia_filter.sv
module inertia_filter
  import inertia_pkg::*;
#(
  parameter int unsigned DELAY = 4,
  parameter dly_mode_e   MODE  = DLY_INERTIAL
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic sig_o
);

  generate
    if (DELAY == 0) begin : g_wire
      assign sig_o = sig_i;
    end else if (MODE == DLY_TRANSPORT) begin : g_transport
      transport_line #(.DELAY(DELAY)) u_line (
        .clk_i(clk_i), .rst_i(rst_i), .sig_i(sig_i), .sig_o(sig_o));
    end else begin : g_inertial
      inertia_pend #(.DELAY(DELAY)) u_pend (
        .clk_i(clk_i), .rst_i(rst_i), .sig_i(sig_i), .sig_o(sig_o));
    end
  endgenerate

endmodule

// File: tb/inertia_filter_bench.sv
module inertia_filter_bench;
  import inertia_pkg::*;

  logic clk = 1'b0;
  logic rst_r = 1'b1;
  logic in_r = 1'b0;
  logic o30, otr, o1, o3, o0;

  always #5ns clk = ~clk;

  inertia_filter #(.DELAY(30)) u_inertia_filter (
    .clk_i(clk), .rst_i(rst_r), .sig_i(in_r), .sig_o(o30));
  inertia_filter #(.DELAY(30), .MODE(DLY_TRANSPORT)) u_trn (
    .clk_i(clk), .rst_i(rst_r), .sig_i(in_r), .sig_o(otr));
  inertia_filter #(.DELAY(1)) u_d1 (
    .clk_i(clk), .rst_i(rst_r), .sig_i(in_r), .sig_o(o1));
  inertia_filter #(.DELAY(3)) u_d3 (
    .clk_i(clk), .rst_i(rst_r), .sig_i(in_r), .sig_o(o3));
  inertia_filter #(.DELAY(0)) u_d0 (
    .clk_i(clk), .rst_i(rst_r), .sig_i(in_r), .sig_o(o0));

  int n_total = 0;
  int n_bad   = 0;
  int tick_n  = 0;
  int last_flip3 = 0;
  logic prev3 = 1'b0;
  logic [63:0] hist = '0;   // hist[0] = most recent sampled input
  logic e30 = 1'b0, e3 = 1'b0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Inertial reference: take the newest level only if the last d samples agree.
  function automatic logic inert(input int d, input logic prev);
    logic same;
    same = 1'b1;
    for (int k = 1; k < d; k++) if (hist[k] !== hist[0]) same = 1'b0;
    return same ? hist[0] : prev;
  endfunction

  // One cycle: account for the edge just past, compare, then drive the next inputs.
  task automatic tick(input logic v, input logic r);
    @(negedge clk);
    tick_n++;
    if (rst_r) begin
      hist = '0; e30 = 1'b0; e3 = 1'b0;
      chk("R1", "inertial30 reset", o30, 1'b0);
      chk("R1", "transport reset", otr, 1'b0);
      chk("R1", "d1 reset", o1, 1'b0);
      chk("R1", "d3 reset", o3, 1'b0);
      prev3 = 1'b0; last_flip3 = tick_n;
    end else begin
      hist = {hist[62:0], in_r};
      e30  = inert(30, e30);
      e3   = inert(3, e3);
      chk("R3", "inertial30 per cycle", o30, e30);
      chk("R4", "inertial3 per cycle", o3, e3);
      chk("R5", "transport per cycle", otr, hist[29]);
      chk("R6", "d1 per cycle", o1, hist[0]);
      if (o3 !== prev3) begin
        chk("R8", "d3 spacing ok", logic'(tick_n - last_flip3 >= 3), 1'b1);
        last_flip3 = tick_n;
        prev3 = o3;
      end
    end
    chk("R7", "d0 follows input", o0, in_r);
    in_r  = v;
    rst_r = r;
  endtask

  task automatic hold(input logic v, input int n);
    repeat (n) tick(v, 1'b0);
  endtask

  // {expected d3 output after segment, level, length}
  localparam logic [9:0] SEG [16] = '{
    {1'b0, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd1}, {1'b0, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd2},
    {1'b1, 1'b1, 8'd3}, {1'b1, 1'b0, 8'd1}, {1'b1, 1'b1, 8'd1}, {1'b1, 1'b0, 8'd2},
    {1'b0, 1'b0, 8'd1}, {1'b1, 1'b1, 8'd4}, {1'b1, 1'b0, 8'd2}, {1'b1, 1'b1, 8'd1},
    {1'b0, 1'b0, 8'd3}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b0, 8'd1}, {1'b1, 1'b1, 8'd5}
  };

  initial begin : watchdog
    #1ms;
    n_total++; n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    // R1: reset held from time zero
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);

    // Narrow-pulse table walked on the DELAY=3 instance (R4)
    for (int i = 0; i < 16; i++) begin
      hold(SEG[i][8], int'(SEG[i][7:0]));
      @(posedge clk); #1;
      chk("R4", $sformatf("table segment %0d", i), o3, SEG[i][9]);
    end
    hold(1'b0, 40);

    // Window of 30: 40 low, 5-cycle pulse, 35 low, 50 high, then low
    hold(1'b0, 40);
    hold(1'b1, 5);
    hold(1'b0, 35);
    chk("R3", "5-cycle pulse swallowed", o30, 1'b0);
    hold(1'b1, 29);
    @(posedge clk); #1;
    chk("R2", "rise not before window", o30, 1'b0);
    hold(1'b1, 1);
    @(posedge clk); #1;
    chk("R2", "rise after 30 samples", o30, 1'b1);
    hold(1'b1, 20);
    hold(1'b0, 29);
    @(posedge clk); #1;
    chk("R2", "fall not before window", o30, 1'b1);
    hold(1'b0, 1);
    @(posedge clk); #1;
    chk("R2", "fall after 30 samples", o30, 1'b0);
    hold(1'b0, 10);

    // Back-to-back pulses one short of the window never accumulate (R4)
    for (int j = 0; j < 6; j++) begin
      hold(1'b1, 29);
      hold(1'b0, 1);
    end
    chk("R4", "repeated 29-cycle pulses", o30, 1'b0);
    hold(1'b0, 35);

    // Mid-run reset with all outputs high (R1)
    hold(1'b1, 40);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk("R1", "transport cleared", otr, 1'b0);
    hold(1'b0, 35);
    chk("R5", "transport stays low after reset", otr, 1'b0);

    // Single-cycle pulses through transport line and DELAY=1 (R5, R6)
    for (int j = 0; j < 4; j++) begin
      hold(1'b1, 1);
      hold(1'b0, 2);
    end
    hold(1'b0, 40);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule